// File: doc/BRIEF.md
# Converter Host Bus Interface

This block is the parallel bus front end of a 12-bit data converter, facing a microprocessor. It decodes active-low chip select, read and write strobes together with two qualifier lines. The register select line chooses between the conversion result and the status/control byte. The byte select line chooses the upper or lower half. A read returns one byte of the result or the status byte on a tri-state bus, shown here as a data output with an enable. A write to the status/control byte updates the output mode, the function of the sample-start pin and the power-down control.

The conversion engine, the calibration logic and the supply monitor are not part of this block. They report through single-bit inputs: a live successive-approximation word, a conversion-done pulse, busy and calibration-running levels, a calibration-overflow pulse and a supply-failure pulse. Two sticky flags collect the pulses. In transparent mode a read sees the live word as its bits are decided. In latched mode a read sees the word captured at the most recent conversion-done pulse, so software can read one result while the next conversion runs.

Top module: `hbi_host_bus`

## Requirements
- R1: `bus_oe` is high exactly while `cs_n` and `rd_n` are both low. At all other times it is low and `bus_out` is zero.
- R2: A read with `reg_sel`=0 returns result bits [11:8] in bus bits [3:0], with bits [7:4] zero, when `byte_hi`=1. It returns result bits [7:0] when `byte_hi`=0.
- R3: In transparent mode (control bit 0 = 0), result reads follow `sar_word` in the same cycle.
- R4: The hold register loads `sar_word` on every cycle with `conv_done` high and keeps its value on all other cycles. In latched mode (control bit 0 = 1), result reads return the hold register.
- R5: A read with `reg_sel`=1 and `byte_hi`=1 returns the status byte. Bit 0 is the latched mode, bit 1 is `cal_active`, bit 2 is the sample-timing select, bit 3 is power-down, bit 4 is always 0, bit 5 is the power-fail flag, bit 6 is the calibration-error flag and bit 7 is `busy_in`.
- R6: A read with `reg_sel`=1 and `byte_hi`=0 is reserved. It drives the bus with `bus_oe` high, and the data value is not specified.
- R7: A write with `cs_n`=`wr_n`=0, `reg_sel`=1 and `byte_hi`=1 loads the control bits from `bus_in` in the first cycle the write strobe is seen, and the new values are visible from the next cycle. Bit 0 is the latched mode, bit 2 is the sample-timing select and bit 3 is power-down. Holding the strobe low does not load again.
- R8: A write with `reg_sel`=0, or with `reg_sel`=1 and `byte_hi`=0, leaves every control bit unchanged.
- R9: After synchronous reset, the latched mode is 0, the sample-timing select is 0, power-down is 1, and both sticky flags are 0, so the status byte reads 0x08.
- R10: A `supply_fail` pulse sets status bit 5 from the next cycle. A control write with bus bit 5 = 0 clears the flag, and a write with bit 5 = 1 leaves it as it was. If a set and a clear fall in the same cycle, the set wins.
- R11: A `cal_ovf` pulse sets status bit 6. A rising edge of `cal_active` clears it. If both happen in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| reg_sel | input | 1 | 1 selects the status/control byte, 0 selects the result |
| byte_hi | input | 1 | Upper-byte select |
| bus_in | input | 8 | Write data from the host |
| bus_out | output | 8 | Read data to the host |
| bus_oe | output | 1 | Drive enable for the data bus |
| sar_word | input | 12 | Live conversion word from the engine |
| conv_done | input | 1 | Pulse marking a finished conversion |
| busy_in | input | 1 | Conversion or calibration in progress |
| cal_active | input | 1 | Calibration in progress |
| cal_ovf | input | 1 | Pulse for a calibration overflow |
| supply_fail | input | 1 | Pulse for a supply failure |
| latched_mode | output | 1 | Current output mode, 1 = latched |
| sample_timing | output | 1 | Sample pin controls sample timing (1) or starts calibration (0) |
| power_down | output | 1 | Power-down control |

## Verification
Two pairs of events can land on the same clock edge. A host write that clears the power-fail flag can coincide with a new supply-failure pulse. A calibration-overflow pulse can coincide with the rising edge of the calibration-running input, which clears the error flag. The bench drives each pair on the same edge, reads the status byte afterwards and expects the flag to be set. This confirms that the set has priority over the clear in both cases.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

    localparam int RES_W_DEF = 12;
    localparam int BYTE_W    = 8;

    localparam int POS_LATCHED = 0;
    localparam int POS_SAMPLE  = 2;
    localparam int POS_PDN     = 3;
    localparam int POS_PFAIL   = 5;

    typedef enum logic [1:0] {
        ACC_RES_LO = 2'b00,
        ACC_RES_HI = 2'b01,
        ACC_RSVD   = 2'b10,
        ACC_STAT   = 2'b11
    } access_e;

    typedef struct packed {
        logic sample_timing;
        logic power_down;
        logic latched;
    } ctrl_t;

    typedef struct packed {
        logic busy;
        logic cal_err;
        logic pwr_fail;
        logic rsvd;
        logic power_down;
        logic sample_timing;
        logic cal_run;
        logic latched;
    } status_t;

    localparam ctrl_t CTRL_RESET = '{sample_timing: 1'b0, power_down: 1'b1, latched: 1'b0};

    function automatic access_e decode_access(input logic reg_sel, input logic byte_hi);
        return access_e'({reg_sel, byte_hi});
    endfunction

    function automatic ctrl_t ctrl_from_bus(input logic [BYTE_W-1:0] d);
        ctrl_t c;
        c.latched       = d[POS_LATCHED];
        c.sample_timing = d[POS_SAMPLE];
        c.power_down    = d[POS_PDN];
        return c;
    endfunction

endpackage

// File: rtl/hbi_decode.sv
module hbi_decode
    import hbi_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cs_n,
    input  logic    rd_n,
    input  logic    wr_n,
    input  logic    reg_sel,
    input  logic    byte_hi,
    output logic    rd_act,
    output logic    ctrl_wr,
    output access_e acc
);

    logic wr_act;
    logic wr_q;

    assign rd_act = ~(cs_n | rd_n);
    assign wr_act = ~(cs_n | wr_n);
    assign acc    = decode_access(reg_sel, byte_hi);

    always_ff @(posedge clk) begin
        if (rst) wr_q <= 1'b0;
        else     wr_q <= wr_act;
    end

    assign ctrl_wr = wr_act & ~wr_q & (acc == ACC_STAT);

    // R7
    one_write_per_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> !ctrl_wr);

endmodule

// File: rtl/hbi_status_reg.sv
module hbi_status_reg
    import hbi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [BYTE_W-1:0] bus_in,
    input  logic              busy_in,
    input  logic              cal_active,
    input  logic              cal_ovf,
    input  logic              supply_fail,
    output ctrl_t             ctrl,
    output status_t           status
);

    logic pwr_fail;
    logic cal_err;
    logic cal_q;
    logic pf_clear;
    logic cal_rise;
    logic unused_bits;

    assign unused_bits = ^{bus_in[7:6], bus_in[4], bus_in[1]};
    assign pf_clear    = ctrl_wr & ~bus_in[POS_PFAIL];
    assign cal_rise    = cal_active & ~cal_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= CTRL_RESET;
            pwr_fail <= 1'b0;
            cal_err  <= 1'b0;
            cal_q    <= 1'b0;
        end else begin
            if (ctrl_wr) ctrl <= ctrl_from_bus(bus_in);
            pwr_fail <= supply_fail | (pwr_fail & ~pf_clear);
            cal_err  <= cal_ovf | (cal_err & ~cal_rise);
            cal_q    <= cal_active;
        end
    end

    always_comb begin
        status               = '0;
        status.latched       = ctrl.latched;
        status.cal_run       = cal_active;
        status.sample_timing = ctrl.sample_timing;
        status.power_down    = ctrl.power_down;
        status.rsvd          = 1'b0;
        status.pwr_fail      = pwr_fail;
        status.cal_err       = cal_err;
        status.busy          = busy_in;
    end

    // R9
    reset_defaults_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctrl.power_down && !ctrl.latched && !ctrl.sample_timing && !pwr_fail && !cal_err));

    // R7
    ctrl_load_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> (ctrl.latched == $past(bus_in[POS_LATCHED]) && ctrl.power_down == $past(bus_in[POS_PDN])));

    // R10
    pfail_set_chk: assert property (@(posedge clk) disable iff (rst)
        supply_fail |=> status.pwr_fail);

    // R11
    calerr_set_chk: assert property (@(posedge clk) disable iff (rst)
        cal_ovf |=> status.cal_err);

endmodule

// File: rtl/hbi_result_hold.sv
module hbi_result_hold #(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             conv_done,
    input  logic [RES_W-1:0] sar_word,
    input  logic             latched,
    output logic [RES_W-1:0] word_out
);

    logic [RES_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst)            hold_q <= '0;
        else if (conv_done) hold_q <= sar_word;
    end

    assign word_out = latched ? hold_q : sar_word;

    // R4
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !conv_done |=> $stable(hold_q));

endmodule

// File: rtl/hbi_host_bus.sv
module hbi_host_bus
    import hbi_pkg::*;
#(
    parameter int RES_W = hbi_pkg::RES_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              reg_sel,
    input  logic              byte_hi,
    input  logic [BYTE_W-1:0] bus_in,
    output logic [BYTE_W-1:0] bus_out,
    output logic              bus_oe,
    input  logic [RES_W-1:0]  sar_word,
    input  logic              conv_done,
    input  logic              busy_in,
    input  logic              cal_active,
    input  logic              cal_ovf,
    input  logic              supply_fail,
    output logic              latched_mode,
    output logic              sample_timing,
    output logic              power_down
);

    localparam int HI_W  = RES_W - BYTE_W;
    localparam int PAD_W = BYTE_W - HI_W;

    logic             rd_act;
    logic             ctrl_wr;
    access_e          acc;
    ctrl_t            ctrl;
    status_t          status;
    logic [RES_W-1:0] word;
    logic [BYTE_W-1:0] rd_byte;

    hbi_decode u_decode (
        .clk     (clk),
        .rst     (rst),
        .cs_n    (cs_n),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .reg_sel (reg_sel),
        .byte_hi (byte_hi),
        .rd_act  (rd_act),
        .ctrl_wr (ctrl_wr),
        .acc     (acc)
    );

    hbi_status_reg u_status (
        .clk         (clk),
        .rst         (rst),
        .ctrl_wr     (ctrl_wr),
        .bus_in      (bus_in),
        .busy_in     (busy_in),
        .cal_active  (cal_active),
        .cal_ovf     (cal_ovf),
        .supply_fail (supply_fail),
        .ctrl        (ctrl),
        .status      (status)
    );

    hbi_result_hold #(.RES_W(RES_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .conv_done (conv_done),
        .sar_word  (sar_word),
        .latched   (ctrl.latched),
        .word_out  (word)
    );

    always_comb begin
        case (acc)
            ACC_RES_LO: rd_byte = word[BYTE_W-1:0];
            ACC_RES_HI: rd_byte = {{PAD_W{1'b0}}, word[RES_W-1:BYTE_W]};
            ACC_STAT:   rd_byte = status;
            default:    rd_byte = '0;
        endcase
    end

    assign bus_oe        = rd_act;
    assign bus_out       = rd_act ? rd_byte : '0;
    assign latched_mode  = ctrl.latched;
    assign sample_timing = ctrl.sample_timing;
    assign power_down    = ctrl.power_down;

    // R8
    ignored_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !wr_n && !(reg_sel && byte_hi)) |=> $stable(ctrl));

    // R1
    bus_release_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_oe |-> (bus_out == '0));

endmodule

// File: tb/hbi_host_bus_test.sv
module hbi_host_bus_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic        reg_sel = 1'b0, byte_hi = 1'b0;
    logic [7:0]  bus_in = '0;
    logic [7:0]  bus_out;
    logic        bus_oe;
    logic [11:0] sar_word = '0;
    logic        conv_done = 1'b0, busy_in = 1'b0, cal_active = 1'b0;
    logic        cal_ovf = 1'b0, supply_fail = 1'b0;
    logic        latched_mode, sample_timing, power_down;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    hbi_host_bus uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .reg_sel(reg_sel), .byte_hi(byte_hi), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe(bus_oe), .sar_word(sar_word),
        .conv_done(conv_done), .busy_in(busy_in), .cal_active(cal_active),
        .cal_ovf(cal_ovf), .supply_fail(supply_fail),
        .latched_mode(latched_mode), .sample_timing(sample_timing),
        .power_down(power_down)
    );

    task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_read(input logic rs, input logic hi, output logic [7:0] d, output logic oe);
        @(negedge clk);
        reg_sel = rs; byte_hi = hi; cs_n = 1'b0; rd_n = 1'b0;
        #1;
        d = bus_out; oe = bus_oe;
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic bus_write(input logic rs, input logic hi, input logic [7:0] d, input logic pf);
        @(negedge clk);
        reg_sel = rs; byte_hi = hi; bus_in = d; cs_n = 1'b0; wr_n = 1'b0; supply_fail = pf;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1; supply_fail = 1'b0;
    endtask

    task automatic expect_status(input string tag, input logic [7:0] exp);
        logic [7:0] d; logic oe;
        bus_read(1'b1, 1'b1, d, oe);
        check(tag, {4'h0, d}, {4'h0, exp});
    endtask

    task automatic test_reset;
        check("R1 idle oe", {11'h0, bus_oe}, 12'h0);
        check("R9 power_down", {11'h0, power_down}, 12'h1);
        check("R9 latched", {11'h0, latched_mode}, 12'h0);
        expect_status("R9 status", 8'h08);
    endtask

    task automatic test_strobes;
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b1; #1;
        check("R1 cs only", {11'h0, bus_oe}, 12'h0);
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b0; #1;
        check("R1 rd only", {11'h0, bus_oe}, 12'h0);
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; #1;
        check("R1 both", {11'h0, bus_oe}, 12'h1);
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b1; #1;
        check("R1 release", {3'h0, bus_oe, bus_out}, 12'h0);
    endtask

    task automatic test_transparent;
        logic [7:0] d; logic oe;
        sar_word = 12'hABC;
        bus_read(1'b0, 1'b1, d, oe); check("R2 hi byte", {4'h0, d}, 12'h00A);
        bus_read(1'b0, 1'b0, d, oe); check("R2 lo byte", {4'h0, d}, 12'h0BC);
        sar_word = 12'h123;
        bus_read(1'b0, 1'b1, d, oe); check("R3 live hi", {4'h0, d}, 12'h001);
        bus_read(1'b0, 1'b0, d, oe); check("R3 live lo", {4'h0, d}, 12'h023);
    endtask

    task automatic test_latched;
        logic [7:0] d; logic oe;
        bus_write(1'b1, 1'b1, 8'h01, 1'b0);
        check("R7 latched pin", {11'h0, latched_mode}, 12'h1);
        @(negedge clk); sar_word = 12'h5A7; conv_done = 1'b1;
        @(negedge clk); conv_done = 1'b0; sar_word = 12'hFFF;
        bus_read(1'b0, 1'b1, d, oe); check("R4 held hi", {4'h0, d}, 12'h005);
        bus_read(1'b0, 1'b0, d, oe); check("R4 held lo", {4'h0, d}, 12'h0A7);
        @(negedge clk); sar_word = 12'h3C2; conv_done = 1'b1;
        @(negedge clk); conv_done = 1'b0; sar_word = 12'h000;
        bus_read(1'b0, 1'b1, d, oe); check("R4 next hi", {4'h0, d}, 12'h003);
        bus_read(1'b0, 1'b0, d, oe); check("R4 next lo", {4'h0, d}, 12'h0C2);
    endtask

    task automatic test_status_read;
        logic [7:0] d; logic oe;
        @(negedge clk); busy_in = 1'b1; cal_active = 1'b1;
        expect_status("R5 busy+cal", 8'h83);
        @(negedge clk); busy_in = 1'b0; cal_active = 1'b0;
        bus_read(1'b1, 1'b0, d, oe);
        check("R6 reserved drives", {11'h0, oe}, 12'h1);
    endtask

    task automatic test_write_once;
        @(negedge clk);
        reg_sel = 1'b1; byte_hi = 1'b1; bus_in = 8'h0C; cs_n = 1'b0; wr_n = 1'b0;
        @(negedge clk); bus_in = 8'h01;
        @(negedge clk);
        @(negedge clk); cs_n = 1'b1; wr_n = 1'b1;
        check("R7 sample pin", {11'h0, sample_timing}, 12'h1);
        check("R7 pdn pin", {11'h0, power_down}, 12'h1);
        expect_status("R7 no reload", 8'h0C);
    endtask

    task automatic test_ignored_write;
        bus_write(1'b0, 1'b1, 8'h0D, 1'b0);
        expect_status("R8 result write", 8'h0C);
        bus_write(1'b1, 1'b0, 8'h01, 1'b0);
        expect_status("R8 reserved write", 8'h0C);
        check("R8 latched pin", {11'h0, latched_mode}, 12'h0);
    endtask

    task automatic test_power_fail;
        @(negedge clk); supply_fail = 1'b1;
        @(negedge clk); supply_fail = 1'b0;
        expect_status("R10 set", 8'h2C);
        bus_write(1'b1, 1'b1, 8'h2C, 1'b0);
        expect_status("R10 write one keeps", 8'h2C);
        bus_write(1'b1, 1'b1, 8'h0C, 1'b0);
        expect_status("R10 write zero clears", 8'h0C);
        bus_write(1'b1, 1'b1, 8'h0C, 1'b1);
        expect_status("R10 set beats clear", 8'h2C);
    endtask

    task automatic test_cal_error;
        @(negedge clk); cal_ovf = 1'b1;
        @(negedge clk); cal_ovf = 1'b0;
        expect_status("R11 set", 8'h6C);
        @(negedge clk); cal_active = 1'b1;
        @(negedge clk);
        expect_status("R11 cal start clears", 8'h2E);
        @(negedge clk); cal_active = 1'b0;
        @(negedge clk); cal_active = 1'b1; cal_ovf = 1'b1;
        @(negedge clk); cal_ovf = 1'b0;
        expect_status("R11 set beats clear", 8'h6E);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_strobes();
        test_transparent();
        test_latched();
        test_status_read();
        test_write_once();
        test_ignored_write();
        test_power_fail();
        test_cal_error();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

endmodule